// File: doc/BRIEF.md
# Radix-4 Booth Sequential Integer Multiplier

This block multiplies two integers over several clock cycles and returns a product twice as wide as the operands. Each operation is either narrow (32-bit operands) or wide (64-bit operands), and either signed or unsigned. The caller chooses both when it issues the operation. The multiplier operand is recoded into radix-4 Booth digits. Each digit comes from an overlapping three-bit window, so each step retires two multiplier bits. A step works through four sub-stages in turn:

- decode the digit;
- choose a multiple of the multiplicand (0, M or 2M);
- form the signed and shifted partial product;
- add it into the running sum.

The clock here stands for one pipeline cycle. Two chained step units run inside each clock, which models step hardware running at twice the pipeline rate. The latency is fixed whatever the operand values or the sign mode: 10 clocks for a narrow multiply and 20 clocks for a wide one. A one-clock `start` pulse issues an operation. `busy` covers the whole run. A one-clock `done` pulse marks the clock in which the high and low product halves become valid. The halves then hold until the next operation finishes.

Top module: `booth_seq_mul`

## Requirements
- R1: In narrow mode (`wide`=0) with `is_signed`=1, the operands are the two's complement values of `op_a[31:0]` and `op_b[31:0]`. At `done`, `lo[31:0]` carries product bits 31..0 and `hi[31:0]` carries product bits 63..32.
- R2: In narrow mode with `is_signed`=0, the operands are the unsigned values of `op_a[31:0]` and `op_b[31:0]`. The unsigned 64-bit product is returned, with the halves placed as in R1.
- R3: In wide mode (`wide`=1) with `is_signed`=1, the 128-bit signed product of `op_a` and `op_b` is returned, with bits 63..0 in `lo` and bits 127..64 in `hi`.
- R4: In wide mode with `is_signed`=0, the 128-bit unsigned product is returned, with the halves placed as in R3.
- R5: `done` is high in exactly the 10th clock after the edge that accepts `start` in narrow mode, and in exactly the 20th clock after it in wide mode. It is never high earlier in that operation.
- R6: `busy` rises on the edge that accepts `start`. It stays high through every clock before `done`, and is low in the clock where `done` is high.
- R7: `done` is high for one clock only.
- R8: A `start` pulse while `busy` is high is ignored. Changes to `op_a`, `op_b`, `wide` and `is_signed` while `busy` is high are also ignored. The running operation keeps its result and its latency.
- R9: `hi` and `lo` change only in the clock where `done` rises. They keep the previous result throughout the next operation.
- R10: After a narrow operation, bits 63..32 of both `hi` and `lo` are zero.
- R11: A synchronous active-high `rst` clears `busy`, `done`, `hi` and `lo` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-clock request to begin a multiply; only accepted while idle |
| op_a | input | 64 | Multiplicand; the low 32 bits are used in narrow mode |
| op_b | input | 64 | Multiplier that gets Booth-recoded; the low 32 bits are used in narrow mode |
| wide | input | 1 | 1 selects 64-bit operands, 0 selects 32-bit operands |
| is_signed | input | 1 | 1 treats the operands as two's complement, 0 as unsigned |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-clock pulse when `hi`/`lo` receive a new result |
| hi | output | 64 | Upper half of the product |
| lo | output | 64 | Lower half of the product |

## Verification
Several properties are checked on every clock by assertions:

- `busy` and `done` never overlap, and `done` lasts one clock.
- `busy` only falls together with `done`.
- The result halves stay still outside a `done` clock.
- The latency, measured by an independent up-counter, matches the mode.
- The latched operands do not move when a `start` arrives during a run.
- Narrow results carry zero upper halves.

Only the directed scenarios can show that the numbers are right: for negative, most-negative, all-ones and zero operands, in each width and sign mode. That includes the extra guard digit that unsigned recoding needs, which only a full-range unsigned multiply exposes.

// File: rtl/mbooth_pkg.sv
package mbooth_pkg;

  // One recoded radix-4 digit: magnitude select plus sign.
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bdig_t;

endpackage

// File: rtl/bm_decode.sv
module bm_decode
  import mbooth_pkg::*;
(
  input  logic [2:0] trip,
  output bdig_t      dig
);

  // Window {b(2i+1), b(2i), b(2i-1)} -> digit in {-2,-1,0,+1,+2}
  always_comb begin
    dig.one = trip[1] ^ trip[0];
    dig.two = (trip == 3'b011) || (trip == 3'b100);
    dig.neg = trip[2] & ~(trip[1] & trip[0]);
  end

endmodule

// File: rtl/bm_select.sv
module bm_select
  import mbooth_pkg::*;
#(
  parameter int MW = 65
) (
  input  logic [MW-1:0] mcand,
  input  bdig_t         dig,
  output logic [MW:0]   mag
);

  // Chooses 0, M or 2M as a signed value one bit wider than M.
  always_comb begin
    if (dig.two)
      mag = {mcand, 1'b0};
    else if (dig.one)
      mag = {mcand[MW-1], mcand};
    else
      mag = '0;
  end

endmodule

// File: rtl/bm_ppgen.sv
module bm_ppgen #(
  parameter int MW    = 65,
  parameter int ACC_W = 128,
  parameter int IDXW  = 6
) (
  input  logic [MW:0]      mag,
  input  logic             neg,
  input  logic [IDXW-1:0]  idx,
  output logic [ACC_W-1:0] pp
);

  logic [ACC_W-1:0] sext;
  logic [ACC_W-1:0] sval;
  logic [IDXW:0]    sh;

  // Sign-extend, apply the digit sign, then weight by 4^idx.
  always_comb begin
    sext = {{(ACC_W-MW-1){mag[MW]}}, mag};
    sval = neg ? (~sext + {{(ACC_W-1){1'b0}}, 1'b1}) : sext;
    sh   = {idx, 1'b0};
    pp   = sval << sh;
  end

endmodule

// File: rtl/bm_step.sv
module bm_step
  import mbooth_pkg::*;
#(
  parameter int MW    = 65,
  parameter int MQW   = 67,
  parameter int ACC_W = 128,
  parameter int IDXW  = 6
) (
  input  logic [MW-1:0]    mcand,
  input  logic [IDXW-1:0]  ndig,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [MQW-1:0]   mq_i,
  input  logic [IDXW-1:0]  idx_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [MQW-1:0]   mq_o,
  output logic [IDXW-1:0]  idx_o
);

  bdig_t            dig;
  logic [MW:0]      mag;
  logic [ACC_W-1:0] pp;
  logic             active;

  // sub-stage 1: digit decode
  bm_decode u_dec (
    .trip (mq_i[2:0]),
    .dig  (dig)
  );

  // sub-stage 2: multiple selection
  bm_select #(.MW(MW)) u_sel (
    .mcand (mcand),
    .dig   (dig),
    .mag   (mag)
  );

  // sub-stage 3: partial product
  bm_ppgen #(.MW(MW), .ACC_W(ACC_W), .IDXW(IDXW)) u_pp (
    .mag (mag),
    .neg (dig.neg),
    .idx (idx_i),
    .pp  (pp)
  );

  // sub-stage 4: accumulation, then advance the multiplier window
  always_comb begin
    active = idx_i < ndig;
    acc_o  = active ? (acc_i + pp) : acc_i;
    mq_o   = {{2{mq_i[MQW-1]}}, mq_i[MQW-1:2]};
    idx_o  = idx_i + IDXW'(1);
  end

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import mbooth_pkg::*;
#(
  parameter int DW    = 64,
  parameter int SPC   = 2,
  parameter int LAT_N = 10,
  parameter int LAT_W = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          wide,
  input  logic          is_signed,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] hi,
  output logic [DW-1:0] lo
);

  localparam int HW    = DW / 2;
  localparam int MW    = DW + 1;
  localparam int MQW   = DW + 3;
  localparam int ACC_W = 2 * DW;
  localparam int IDXW  = $clog2(SPC * LAT_W + 1);
  localparam int CNTW  = $clog2(LAT_W + 1);

  logic [MW-1:0]    mcand_q;
  logic [MQW-1:0]   mq_q;
  logic [ACC_W-1:0] acc_q;
  logic [IDXW-1:0]  idx_q;
  logic [IDXW-1:0]  ndig_q;
  logic [CNTW-1:0]  cnt_q;
  logic             wide_q;

  logic             take;
  logic [MW-1:0]    a_ext;
  logic [DW+1:0]    b_ext;
  logic [IDXW-1:0]  ndig_d;
  logic [CNTW-1:0]  cnt_d;

  assign take = start && !busy;

  // Operand conditioning; the unsigned case gets a guard digit.
  always_comb begin
    if (wide) begin
      a_ext  = {is_signed & op_a[DW-1], op_a};
      b_ext  = {{2{is_signed & op_b[DW-1]}}, op_b};
      ndig_d = IDXW'(DW / 2);
      cnt_d  = CNTW'(LAT_W - 1);
    end else begin
      a_ext  = {{(MW-HW){is_signed & op_a[HW-1]}}, op_a[HW-1:0]};
      b_ext  = {{(DW+2-HW){is_signed & op_b[HW-1]}}, op_b[HW-1:0]};
      ndig_d = IDXW'(HW / 2);
      cnt_d  = CNTW'(LAT_N - 1);
    end
    if (!is_signed)
      ndig_d = ndig_d + IDXW'(1);
  end

  // SPC chained Booth steps per clock model the double-rate step logic.
  logic [ACC_W-1:0] acc_c [SPC+1];
  logic [MQW-1:0]   mq_c  [SPC+1];
  logic [IDXW-1:0]  idx_c [SPC+1];

  assign acc_c[0] = acc_q;
  assign mq_c[0]  = mq_q;
  assign idx_c[0] = idx_q;

  for (genvar s = 0; s < SPC; s++) begin : g_step
    bm_step #(.MW(MW), .MQW(MQW), .ACC_W(ACC_W), .IDXW(IDXW)) u_step (
      .mcand (mcand_q),
      .ndig  (ndig_q),
      .acc_i (acc_c[s]),
      .mq_i  (mq_c[s]),
      .idx_i (idx_c[s]),
      .acc_o (acc_c[s+1]),
      .mq_o  (mq_c[s+1]),
      .idx_o (idx_c[s+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      hi      <= '0;
      lo      <= '0;
      mcand_q <= '0;
      mq_q    <= '0;
      acc_q   <= '0;
      idx_q   <= '0;
      ndig_q  <= '0;
      cnt_q   <= '0;
      wide_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) begin
        busy    <= 1'b1;
        mcand_q <= a_ext;
        mq_q    <= {b_ext, 1'b0};
        acc_q   <= '0;
        idx_q   <= '0;
        ndig_q  <= ndig_d;
        cnt_q   <= cnt_d;
        wide_q  <= wide;
      end else if (busy) begin
        if (cnt_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (wide_q) begin
            lo <= acc_q[DW-1:0];
            hi <= acc_q[ACC_W-1:DW];
          end else begin
            lo <= {{HW{1'b0}}, acc_q[HW-1:0]};
            hi <= {{HW{1'b0}}, acc_q[DW-1:HW]};
          end
        end else begin
          cnt_q <= cnt_q - CNTW'(1);
          acc_q <= acc_c[SPC];
          mq_q  <= mq_c[SPC];
          idx_q <= idx_c[SPC];
        end
      end
    end
  end

  // Independent up-counter that measures the age of the running operation.
  logic [CNTW-1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)
      age_q <= '0;
    else if (take)
      age_q <= '0;
    else if (busy)
      age_q <= age_q + CNTW'(1);
  end

  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (age_q == (wide_q ? CNTW'(LAT_W) : CNTW'(LAT_N))));

  p_start_sets_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_busy_ends_with_done_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(mcand_q) && $stable(wide_q) && $stable(ndig_q)));

  p_hold_result_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(hi) && $stable(lo)));

  p_narrow_upper_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (done && !wide_q) |-> ((hi[DW-1:HW] == '0) && (lo[DW-1:HW] == '0)));

endmodule

// File: tb/sim_booth_seq_mul.sv
module sim_booth_seq_mul;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        wide = 1'b0;
  logic        is_signed = 1'b0;
  logic        busy, done;
  logic [63:0] hi, lo;

  int total = 0;
  int bad   = 0;
  logic [63:0] prev_hi = '0;
  logic [63:0] prev_lo = '0;

  always #4 clk = ~clk;

  booth_seq_mul u0 (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op_a      (op_a),
    .op_b      (op_b),
    .wide      (wide),
    .is_signed (is_signed),
    .busy      (busy),
    .done      (done),
    .hi        (hi),
    .lo        (lo)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R11: reset state
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R11 busy/done", {busy, done}, 0);
    check(hi == '0 && lo == '0, "R11 hi/lo", {hi, lo}, 0);
    rst = 1'b0;
    @(negedge clk);
    prev_hi = '0;
    prev_lo = '0;
  endtask

  // Issues one multiply and checks timing and result; poke>0 injects a
  // start with altered operands that many clocks after acceptance (R8).
  task automatic t_mul(input logic [63:0] a, input logic [63:0] b, input bit w,
                       input bit s, input int poke, input string req);
    logic [127:0] ea, eb, p;
    logic [63:0]  exp_hi, exp_lo;
    int lat;
    bit tim_ok, hold_ok;
    if (w) begin
      ea = s ? {{64{a[63]}}, a} : {64'b0, a};
      eb = s ? {{64{b[63]}}, b} : {64'b0, b};
    end else begin
      ea = s ? {{96{a[31]}}, a[31:0]} : {96'b0, a[31:0]};
      eb = s ? {{96{b[31]}}, b[31:0]} : {96'b0, b[31:0]};
    end
    p = ea * eb;
    if (w) begin
      exp_lo = p[63:0];
      exp_hi = p[127:64];
    end else begin
      exp_lo = {32'b0, p[31:0]};
      exp_hi = {32'b0, p[63:32]};
    end
    lat = w ? 20 : 10;
    op_a = a; op_b = b; wide = w; is_signed = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tim_ok = (busy == 1'b1) && (done == 1'b0);
    hold_ok = 1'b1;
    for (int j = 1; j <= lat; j++) begin
      if (poke > 0 && j == poke) begin
        start = 1'b1; op_a = ~a; op_b = ~b; wide = ~w; is_signed = ~s;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (j < lat) begin
        if (!(busy == 1'b1 && done == 1'b0)) tim_ok = 1'b0;
        if (!(hi == prev_hi && lo == prev_lo)) hold_ok = 1'b0;
      end
    end
    start = 1'b0;
    check(tim_ok, {req, " R5 R6 not done early / busy held"}, {busy, done}, 2'b10);
    check(hold_ok, {req, " R9 previous result held"}, {hi, lo}, {prev_hi, prev_lo});
    check(done == 1'b1 && busy == 1'b0, {req, " R5 R6 done at latency"}, {busy, done}, 2'b01);
    check(hi == exp_hi && lo == exp_lo, req, {hi, lo}, {exp_hi, exp_lo});
    @(negedge clk);
    check(done == 1'b0, {req, " R7 single-clock done"}, done, 0);
    check(hi == exp_hi && lo == exp_lo, {req, " R9 result kept"}, {hi, lo}, {exp_hi, exp_lo});
    prev_hi = exp_hi;
    prev_lo = exp_lo;
  endtask

  task automatic t_signed32();
    t_mul(64'h0000_0000_FFFF_FFF9, 64'h0000_0000_0000_1234, 1'b0, 1'b1, 0, "R1 neg*pos");
    t_mul(64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 1'b0, 1'b1, 0, "R1 min*min");
    t_mul(64'hDEAD_BEEF_7FFF_FFFF, 64'h1234_5678_8000_0001, 1'b0, 1'b1, 0, "R1 R10 upper ignored");
  endtask

  task automatic t_unsigned32();
    t_mul(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0, 0, "R2 ones*ones");
    t_mul(64'h0000_0000_8000_0000, 64'h0000_0000_0000_0003, 1'b0, 1'b0, 0, "R2 msb*3");
  endtask

  task automatic t_signed64();
    t_mul(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 1'b1, 0, "R3 min*min");
    t_mul(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0005, 1'b1, 1'b1, 0, "R3 -1*5");
    t_mul(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b1, 1'b1, 0, "R3 mixed");
  endtask

  task automatic t_unsigned64();
    t_mul(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 0, "R4 ones*ones");
    t_mul(64'h0000_0000_0000_0000, 64'hAAAA_5555_AAAA_5555, 1'b1, 1'b0, 0, "R4 zero");
  endtask

  task automatic t_ignore_busy();
    t_mul(64'h0000_0000_0000_0BAD, 64'h0000_0000_FFFF_0001, 1'b0, 1'b1, 3, "R8 narrow poked");
    t_mul(64'h7654_3210_0000_0007, 64'hF000_0000_0000_0003, 1'b1, 1'b0, 12, "R8 wide poked");
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_signed32();
    t_unsigned32();
    t_signed64();
    t_unsigned64();
    t_ignore_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule